// File: doc/BRIEF.md
# Adaptive Binary Range Decoder

This block is the arithmetic core of a byte-fed binary range decoder. It holds a 32-bit interval width (`range`) and a 32-bit offset into that interval (`code`). Compressed bytes arrive on a valid/ready byte port. The caller keeps the probability tables and does the context selection. It asks for one bit at a time and chooses between two request kinds. A modelled request supplies an 11-bit adaptive probability, which is the chance of a zero scaled to 2048. The block returns the decoded bit and the updated probability. A direct request decodes a bit where both values are equally likely.

After reset the block takes a five-byte prologue into `code`, and the first of those bytes must be zero. Before each decode it tops up `range` with at most one byte. If that byte has not arrived yet, it waits with all its state frozen. A completed request is reported by a single-cycle `done` pulse. A `code_zero` output lets the caller confirm, once the stream ends, that the offset has returned to zero, as it does for an intact stream.

Top module: `range_bit_decoder`

## Requirements
- R1: While reset is active and on the first cycle after it: `done`=0, `data_error`=0, `init_done`=0, `req_ready`=0 and `byte_ready`=1. Internally range=0xFFFFFFFF and code=0.
- R2: The block consumes exactly five bytes, shifting each into the low byte of code (code = code<<8 | byte). `req_ready` stays 0 until all five are taken, then `init_done` and `req_ready` go to 1.
- R3: If the first prologue byte is not 0x00, `data_error` rises and stays at 1. After that no further bytes are accepted (`byte_ready`=0) and no requests are accepted (`req_ready`=0).
- R4: For a modelled request (`req_direct`=0) the block computes bound = (range>>11)*prob. The bit is 0 when code < bound, unsigned. Otherwise the bit is 1, and both range and code are reduced by bound. For a 0 bit, range becomes bound.
- R5: The returned probability is prob + ((2048-prob)>>5) for a 0 bit and prob - (prob>>5) for a 1 bit. Callers keep prob within 31..2017, a range these updates never leave.
- R6: For a direct request (`req_direct`=1), range is halved and t = code - range is formed. If bit 31 of t is set, code is kept and the bit is 0. Otherwise code becomes t and the bit is 1. `done_prob` echoes `req_prob`.
- R7: Before each decode the block consumes exactly one byte if range < 2^24, and none otherwise. The step is range<<=8 and code = code<<8 | byte. `byte_ready` is 1 only while that byte is needed, or during the prologue.
- R8: While a needed byte is missing, range and code hold and `done` stays 0. Decoding resumes when the byte arrives, with the same result as without the stall.
- R9: `code_zero` is 1 exactly when the code register equals zero.
- R10: `done` is a one-cycle pulse, one per accepted request. `done_bit` and `done_prob` are valid while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| byte_valid | input | 1 | Compressed byte available |
| byte_data | input | 8 | Compressed byte |
| byte_ready | output | 1 | Block takes the byte this cycle |
| req_valid | input | 1 | Bit request presented |
| req_direct | input | 1 | 1: equiprobable bit, 0: modelled bit |
| req_prob | input | 11 | Probability of a zero, scaled to 2048 |
| req_ready | output | 1 | Block idle and able to accept a request |
| done | output | 1 | One-cycle completion pulse |
| done_bit | output | 1 | Decoded bit |
| done_prob | output | 11 | Updated probability (echo for direct bits) |
| init_done | output | 1 | Prologue finished without error |
| data_error | output | 1 | First prologue byte was nonzero |
| code_zero | output | 1 | Code register equals zero |

## Verification
The assertions cover the properties that hold on every cycle. `done` never lasts two cycles. The error flag stays set once raised. A stalled top-up freezes range and code. No decode starts with range below 2^24. A zero bit never lowers the probability. The prologue ends only on an accepted byte.

The numeric results can only be shown by the bench's scenarios. These are the bit values, the probability updates, the number of bytes consumed per bit and the `code_zero` value. The bench checks them against a reference model over random streams, adaptive contexts, forced starvation, an all-zero stream and a stream that is bad from its first byte.

// File: rtl/range_bit_decoder.sv
module range_bit_decoder #(
  parameter int PW         = 11,
  parameter int MOVE       = 5,
  parameter int TOP_BITS   = 24,
  parameter int INIT_BYTES = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_valid,
  input  logic [7:0]    byte_data,
  output logic          byte_ready,
  input  logic          req_valid,
  input  logic          req_direct,
  input  logic [PW-1:0] req_prob,
  output logic          req_ready,
  output logic          done,
  output logic          done_bit,
  output logic [PW-1:0] done_prob,
  output logic          init_done,
  output logic          data_error,
  output logic          code_zero
);
  localparam int CW = $clog2(INIT_BYTES + 1);
  localparam logic [31:0] TOP = 32'h1 << TOP_BITS;
  localparam logic [PW:0] TOTAL = (PW+1)'(1) << PW;

  typedef enum logic [2:0] {ST_INIT, ST_IDLE, ST_NORM, ST_CALC, ST_ERR} st_t;

  st_t           st;
  logic [31:0]   range_r, code_r;
  logic [CW-1:0] init_cnt;
  logic          dir_q;
  logic [PW-1:0] prob_q;

  wire         need_byte = range_r < TOP;
  wire [31:0]  bound     = (range_r >> PW) * {{(32-PW){1'b0}}, prob_q};
  wire         pbit      = code_r >= bound;
  wire [31:0]  half      = range_r >> 1;
  wire [31:0]  dsub      = code_r - half;
  wire [PW:0]  p_ext     = {1'b0, prob_q};
  wire [PW:0]  p_up      = p_ext + ((TOTAL - p_ext) >> MOVE);
  wire [PW:0]  p_dn      = p_ext - (p_ext >> MOVE);

  assign byte_ready = (st == ST_INIT) || (st == ST_NORM && need_byte);
  assign req_ready  = st == ST_IDLE;
  assign init_done  = st != ST_INIT && st != ST_ERR;
  assign data_error = st == ST_ERR;
  assign code_zero  = code_r == 32'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_INIT;
      range_r   <= '1;
      code_r    <= '0;
      init_cnt  <= CW'(INIT_BYTES);
      dir_q     <= 1'b0;
      prob_q    <= '0;
      done      <= 1'b0;
      done_bit  <= 1'b0;
      done_prob <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_INIT:
          if (byte_valid) begin
            if (init_cnt == CW'(INIT_BYTES) && byte_data != 8'h00) begin
              st <= ST_ERR;
            end else begin
              code_r   <= {code_r[23:0], byte_data};
              init_cnt <= init_cnt - 1'b1;
              if (init_cnt == CW'(1)) st <= ST_IDLE;
            end
          end
        ST_IDLE:
          if (req_valid) begin
            dir_q  <= req_direct;
            prob_q <= req_prob;
            st     <= ST_NORM;
          end
        ST_NORM:
          if (!need_byte) begin
            st <= ST_CALC;
          end else if (byte_valid) begin
            range_r <= {range_r[23:0], 8'h00};
            code_r  <= {code_r[23:0], byte_data};
            st      <= ST_CALC;
          end
        ST_CALC: begin
          done <= 1'b1;
          st   <= ST_IDLE;
          if (dir_q) begin
            range_r   <= half;
            done_prob <= prob_q;
            done_bit  <= ~dsub[31];
            if (!dsub[31]) code_r <= dsub;
          end else if (pbit) begin
            range_r   <= range_r - bound;
            code_r    <= code_r - bound;
            done_bit  <= 1'b1;
            done_prob <= p_dn[PW-1:0];
          end else begin
            range_r   <= bound;
            done_bit  <= 1'b0;
            done_prob <= p_up[PW-1:0];
          end
        end
        default: st <= ST_ERR;
      endcase
    end
  end

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_err_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    data_error |=> data_error && !byte_ready && !req_ready);

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_NORM && byte_ready && !byte_valid) |=>
      $stable(range_r) && $stable(code_r) && !done);

  p_norm_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CALC) |-> range_r >= TOP);

  p_prob_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !dir_q && !done_bit) |-> done_prob >= prob_q);

  p_init_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> $past(byte_valid && byte_ready));
endmodule

// File: tb/range_bit_decoder_tb.sv
module range_bit_decoder_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic byte_valid = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic byte_ready;
  logic req_valid = 1'b0, req_direct = 1'b0;
  logic [10:0] req_prob = 11'd0;
  logic req_ready, done, done_bit, init_done, data_error, code_zero;
  logic [10:0] done_prob;

  always #2.5 clk = ~clk;

  range_bit_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
    .byte_ready(byte_ready), .req_valid(req_valid), .req_direct(req_direct),
    .req_prob(req_prob), .req_ready(req_ready), .done(done), .done_bit(done_bit),
    .done_prob(done_prob), .init_done(init_done), .data_error(data_error),
    .code_zero(code_zero));

  int errors = 0, checks = 0;
  logic [7:0] strm [1024];
  int byte_idx;
  bit feed_en = 1'b0;
  int gap_pct = 0;
  logic [31:0] m_range, m_code;
  int m_pos;
  logic [10:0] ctx [8];

  always @(posedge clk or negedge rst_n)
    if (!rst_n) byte_idx <= 0;
    else if (byte_valid && byte_ready) byte_idx <= byte_idx + 1;

  initial forever begin
    @(negedge clk);
    byte_valid <= feed_en && byte_idx < 1024 && ($urandom_range(99) >= gap_pct);
    byte_data  <= strm[byte_idx < 1024 ? byte_idx : 0];
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model(input bit dir, input logic [10:0] p, output bit b, output logic [10:0] np);
    logic [31:0] bnd, t;
    if (m_range < 32'h0100_0000) begin
      m_range = m_range << 8;
      m_code  = (m_code << 8) | 32'(strm[m_pos]);
      m_pos++;
    end
    if (dir) begin
      m_range = m_range >> 1;
      t = m_code - m_range;
      b = ~t[31];
      if (b) m_code = t;
      np = p;
    end else begin
      bnd = (m_range >> 11) * 32'(p);
      if (m_code < bnd) begin
        b = 1'b0; m_range = bnd; np = p + 11'((12'd2048 - 12'(p)) >> 5);
      end else begin
        b = 1'b1; m_range -= bnd; m_code -= bnd; np = p - (p >> 5);
      end
    end
  endtask

  task automatic do_reset(input int kind);
    rst_n = 1'b0;
    feed_en = 1'b0;
    for (int i = 0; i < 1024; i++)
      strm[i] = (kind == 1) ? 8'h00 : 8'($urandom_range(255));
    strm[0] = (kind == 2) ? 8'h5A : 8'h00;
    for (int i = 0; i < 8; i++) ctx[i] = 11'd1024;
    repeat (3) @(negedge clk);
    chk(!done && !data_error && !init_done && !req_ready && byte_ready, "R1 reset outputs",
        {done, data_error, init_done, req_ready, byte_ready}, 5'b00001);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!req_ready && byte_ready && !done, "R1 after release", {req_ready, byte_ready}, 2'b01);
    m_range = 32'hFFFF_FFFF;
    m_code = {strm[1], strm[2], strm[3], strm[4]};
    m_pos = 5;
  endtask

  task automatic do_op(input bit dir, input logic [10:0] p, input bit starve,
                       output logic [10:0] got_p);
    bit eb; logic [10:0] ep; int start_idx; bit st_now;
    while (!req_ready) @(negedge clk);
    st_now = starve && (m_range < 32'h0100_0000);
    if (st_now) begin feed_en = 1'b0; @(negedge clk); end
    start_idx = byte_idx;
    model(dir, p, eb, ep);
    req_valid = 1'b1; req_direct = dir; req_prob = p;
    @(negedge clk);
    req_valid = 1'b0;
    if (st_now) begin
      repeat (10) begin
        @(negedge clk);
        chk(!done, "R8 no done while starved", done, 0);
      end
      chk(byte_idx == start_idx, "R8 no byte while starved", byte_idx, start_idx);
      feed_en = 1'b1;
    end
    while (!done) @(negedge clk);
    chk(done_bit == eb, dir ? "R6 direct bit" : "R4 modelled bit", done_bit, eb);
    chk(done_prob == ep, dir ? "R6 prob echo" : "R5 prob update", done_prob, ep);
    chk(byte_idx == m_pos, "R7 bytes consumed", byte_idx, m_pos);
    chk(code_zero == (m_code == 0), "R9 code_zero", code_zero, m_code == 0);
    @(negedge clk);
    chk(!done, "R10 done single pulse", done, 0);
    got_p = done_prob;
  endtask

  initial begin
    logic [10:0] gp;
    int c;
    void'($urandom(32'h5EED_0042));
    do_reset(0);
    repeat (5) @(negedge clk);
    chk(!req_ready && !init_done, "R2 no request before prologue", req_ready, 0);
    feed_en = 1'b1;
    while (!req_ready) @(negedge clk);
    chk(byte_idx == 5 && init_done, "R2 five prologue bytes", byte_idx, 5);
    gap_pct = 30;
    for (int i = 0; i < 150; i++) begin
      c = $urandom_range(7);
      if ($urandom_range(3) == 0) do_op(1'b1, ctx[c], 1'b0, gp);
      else begin do_op(1'b0, ctx[c], 1'b0, gp); ctx[c] = gp; end
    end
    for (int i = 0; i < 40; i++)
      do_op(1'b0, 11'($urandom_range(2017, 31)), 1'b0, gp);
    do_op(1'b0, 11'd31, 1'b0, gp);
    do_op(1'b0, 11'd2017, 1'b0, gp);
    for (int i = 0; i < 30; i++) do_op(1'b1, 11'd1024, 1'b1, gp);
    gap_pct = 0;
    do_reset(1);
    feed_en = 1'b1;
    for (int i = 0; i < 12; i++) do_op(i[0], 11'd1024, 1'b0, gp);
    chk(code_zero == 1'b1, "R9 zero stream ends at zero", code_zero, 1);
    do_reset(2);
    feed_en = 1'b1;
    repeat (10) @(negedge clk);
    chk(data_error == 1'b1, "R3 error flag", data_error, 1);
    chk(byte_idx == 1, "R3 no bytes after error", byte_idx, 1);
    chk(!byte_ready && !req_ready && !init_done, "R3 block halted",
        {byte_ready, req_ready, init_done}, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule